// File: doc/BRIEF.md
# Receive Line Decoder and Output Formatter

This block sits behind clock and data recovery on a coaxial line receiver. It takes one bit period per rising edge of the recovered clock, as a positive-rail strobe and a negative-rail strobe, and formats the result for a downstream framer. In bipolar mode the two rails are passed out unchanged. In binary mode the stream is decoded under a three-zero substitution code (00V / B0V) or a four-zero substitution code (000V / B00V). The first output then carries the recovered ones and zeros, and the second output flags line-code violations.

Every bit passes through a four-slot window, so a substitution can be seen whole and its pulses turned back into zeros before the bit leaves. A saturating violation counter runs beside the flag output. A latch strobe copies the counter into a holding register and restarts the count. The output update edge can be chosen. An active-low enable releases the data, flag and clock outputs to high impedance while decoding and counting carry on.

Top module: `rx_line_decoder`

## Requirements
- R1: With `bin_mode`=0, `dat_o` equals `pos_i` and `flg_o` equals `neg_i` of the same bit, delayed by four bit periods: a bit sampled on rising edge k is shown after rising edge k+3 (`clk_inv`=1) or after the falling edge that follows it (`clk_inv`=0).
- R2: With `bin_mode`=1, `dat_o` is 1 for a received pulse (either rail) and 0 for a bit period with neither rail, except where R3 or R4 clears it; `flg_o` is 1 for each bit flagged under R5, R6 or R7. The latency is the same as in R1.
- R3: With `code_hdb3`=1, a pulse of the same polarity as the previous pulse (a violation pulse V) ends a valid substitution when it follows three empty bits (000V), or follows a single-rail pulse B of V's polarity and then two empty bits (B00V). All four bits are output as 0, and none of them is flagged.
- R4: With `code_hdb3`=0, a V pulse ends a valid substitution when it follows two empty bits (00V), or follows a single-rail pulse B of V's polarity and then one empty bit (B0V). All three bits are output as 0, and none of them is flagged.
- R5: A V pulse that does not end a valid substitution is output as 1 and flagged. The first pulse after reset is never a V pulse.
- R6: In binary mode, a run of empty bits is flagged once, on the bit that brings it to 4 (`code_hdb3`=1) or to 3 (`code_hdb3`=0). A three-zero run under the four-zero code is not flagged.
- R7: A bit period with both rails high is output as 1 and flagged. It does not change the remembered pulse polarity.
- R8: `clk_inv`=0 makes `dat_o`/`flg_o` change on the falling edge of `rclk_i`; `clk_inv`=1 makes them change on the rising edge.
- R9: `oe_n`=0 puts `dat_o`, `flg_o` and `clk_o` at high impedance. Decoding and counting go on unchanged. With `oe_n`=1, `clk_o` follows `rclk_i`.
- R10: The counter adds one for each flagged bit as it reaches the output. It stops at 2^CNT_W-1 (65535 by default) and does not wrap.
- R11: A one-cycle `cnt_latch` copies the count into `viol_hold` at the next rising edge and restarts the count from the flag leaving the window in that same cycle.
- R12: After reset, `dat_o`, `flg_o` and `viol_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk_i | input | 1 | Recovered bit clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pos_i | input | 1 | Positive-rail pulse for the current bit |
| neg_i | input | 1 | Negative-rail pulse for the current bit |
| bin_mode | input | 1 | 1 = decoded binary output, 0 = rails passed through |
| code_hdb3 | input | 1 | 1 = four-zero substitution code, 0 = three-zero substitution code |
| clk_inv | input | 1 | 1 = outputs change on the rising edge, 0 = on the falling edge |
| oe_n | input | 1 | Active-low output enable for dat_o, flg_o, clk_o |
| cnt_latch | input | 1 | Copy the violation count to viol_hold and restart it |
| dat_o | output | 1 | Positive rail or decoded data |
| flg_o | output | 1 | Negative rail or violation flag |
| clk_o | output | 1 | Recovered clock out |
| viol_hold | output | CNT_W | Latched violation count |

## Verification
The assertions assume that the rails, mode, code and latch inputs are stable around each rising edge of `rclk_i`, that `cnt_latch` is one cycle wide, and that a fixed four-period latency is wanted. They check the pre-tri-state output values, because high impedance cannot be seen as a logic value. The stimulus changes every input on the falling edge only. It turns binary mode on at the first bit of each decoded stream and returns to bipolar idle with both rails low, so reset idle never builds a zero run. Each decoded stream ends with legal alternating pulses, so no violation outside the pattern under test reaches the counter.

// File: rtl/rx_ldec_pkg.sv
`timescale 1ns/1ps
package rx_ldec_pkg;
  // One bit period as held in the decode window.
  typedef struct packed {
    logic p;     // positive rail seen on the line
    logic n;     // negative rail seen on the line
    logic pol;   // polarity of a single-rail pulse (1 = positive)
    logic data;  // decoded bit after substitution removal
    logic viol;  // violation flag for this bit
  } slot_t;

  typedef enum logic {
    CODE_ZS3 = 1'b0,
    CODE_ZS4 = 1'b1
  } code_e;
endpackage

// File: rtl/rx_rst_sync.sv
`timescale 1ns/1ps
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rx_zero_run.sv
`timescale 1ns/1ps
module rx_zero_run #(
  parameter int RUN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic line_bit,
  input  logic long_code,
  output logic run_hit
);
  localparam logic [RUN_W-1:0] RUN_MAX   = '1;
  localparam logic [RUN_W-1:0] HIT_SHORT = RUN_W'(2);
  localparam logic [RUN_W-1:0] HIT_LONG  = RUN_W'(3);

  logic [RUN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] hit_at;

  always_comb begin
    hit_at  = long_code ? HIT_LONG : HIT_SHORT;
    run_hit = en && !line_bit && (run_q == hit_at);
    if (!en || line_bit)      run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + RUN_W'(1);
    else                      run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/rx_subst_window.sv
`timescale 1ns/1ps
module rx_subst_window
  import rx_ldec_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p_in,
  input  logic n_in,
  input  code_e code,
  input  logic run_hit,
  output logic out_p,
  output logic out_n,
  output logic out_data,
  output logic out_viol
);
  localparam int SPAN_ZS4 = 3;
  localparam int SPAN_ZS3 = 2;

  slot_t win_q [WIN];
  slot_t win_d [WIN];
  slot_t cur;
  logic  have_q, have_d;
  logic  lpol_q, lpol_d;
  logic  single, both, is_v;
  logic  empty0, empty1, empty2;
  logic  b_at1, b_at2;
  logic  sub_zs4, sub_zs3, sub;
  int    span;

  always_comb begin
    single  = p_in ^ n_in;
    both    = p_in & n_in;
    is_v    = single && have_q && (p_in == lpol_q);
    empty0  = !(win_q[0].p || win_q[0].n);
    empty1  = !(win_q[1].p || win_q[1].n);
    empty2  = !(win_q[2].p || win_q[2].n);
    b_at1   = (win_q[1].p ^ win_q[1].n) && (win_q[1].pol == p_in) && !win_q[1].viol;
    b_at2   = (win_q[2].p ^ win_q[2].n) && (win_q[2].pol == p_in) && !win_q[2].viol;
    sub_zs4 = is_v && empty0 && empty1 && (empty2 || b_at2);
    sub_zs3 = is_v && empty0 && (empty1 || b_at1);
    sub     = (code == CODE_ZS4) ? sub_zs4 : sub_zs3;
    span    = (code == CODE_ZS4) ? SPAN_ZS4 : SPAN_ZS3;

    cur.p    = p_in;
    cur.n    = n_in;
    cur.pol  = p_in;
    cur.data = (p_in || n_in) && !sub;
    cur.viol = (is_v && !sub) || both || run_hit;

    win_d[0] = cur;
    for (int k = 1; k < WIN; k++) begin
      win_d[k] = win_q[k-1];
      if (sub && ((k - 1) < span)) win_d[k].data = 1'b0;
    end

    have_d = have_q || single;
    lpol_d = single ? p_in : lpol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WIN; k++) win_q[k] <= '0;
      have_q <= 1'b0;
      lpol_q <= 1'b0;
    end else begin
      for (int k = 0; k < WIN; k++) win_q[k] <= win_d[k];
      have_q <= have_d;
      lpol_q <= lpol_d;
    end
  end

  assign out_p    = win_q[WIN-1].p;
  assign out_n    = win_q[WIN-1].n;
  assign out_data = win_q[WIN-1].data;
  assign out_viol = win_q[WIN-1].viol;
endmodule

// File: rtl/rx_viol_counter.sv
`timescale 1ns/1ps
module rx_viol_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             hold_en;

  always_comb begin
    hold_en = latch;
    hold_d  = cnt_q;
    if (latch)                       cnt_d = inc ? CNT_W'(1) : '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign cnt  = cnt_q;
  assign hold = hold_q;
endmodule

// File: rtl/rx_out_stage.sv
`timescale 1ns/1ps
module rx_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_inv,
  input  logic a_in,
  input  logic b_in,
  output logic a_sel,
  output logic b_sel
);
  logic a_fall_q, b_fall_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_fall_q <= 1'b0;
      b_fall_q <= 1'b0;
    end else begin
      a_fall_q <= a_in;
      b_fall_q <= b_in;
    end
  end

  assign a_sel = clk_inv ? a_in : a_fall_q;
  assign b_sel = clk_inv ? b_in : b_fall_q;
endmodule

// File: rtl/rx_line_decoder.sv
`timescale 1ns/1ps
module rx_line_decoder
  import rx_ldec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN   = 4,
  parameter int RUN_W = 3
) (
  input  logic             rclk_i,
  input  logic             arst_n,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             bin_mode,
  input  logic             code_hdb3,
  input  logic             clk_inv,
  input  logic             oe_n,
  input  logic             cnt_latch,
  output logic             dat_o,
  output logic             flg_o,
  output logic             clk_o,
  output logic [CNT_W-1:0] viol_hold
);
  logic             srst_n;
  logic             run_hit;
  logic             w_p, w_n, w_data, w_viol;
  logic             a_val, b_val;
  logic             a_sel, b_sel;
  logic [CNT_W-1:0] viol_cnt;
  code_e            code;

  assign code = code_e'(code_hdb3);

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(rclk_i), .arst_n(arst_n), .srst_n(srst_n)
  );

  rx_zero_run #(.RUN_W(RUN_W)) u_run (
    .clk(rclk_i), .rst_n(srst_n), .en(bin_mode),
    .line_bit(pos_i | neg_i), .long_code(code_hdb3), .run_hit(run_hit)
  );

  rx_subst_window #(.WIN(WIN)) u_win (
    .clk(rclk_i), .rst_n(srst_n), .p_in(pos_i), .n_in(neg_i),
    .code(code), .run_hit(run_hit),
    .out_p(w_p), .out_n(w_n), .out_data(w_data), .out_viol(w_viol)
  );

  rx_viol_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(rclk_i), .rst_n(srst_n), .inc(w_viol), .latch(cnt_latch),
    .cnt(viol_cnt), .hold(viol_hold)
  );

  assign a_val = bin_mode ? w_data : w_p;
  assign b_val = bin_mode ? w_viol : w_n;

  rx_out_stage u_out (
    .clk(rclk_i), .rst_n(srst_n), .clk_inv(clk_inv),
    .a_in(a_val), .b_in(b_val), .a_sel(a_sel), .b_sel(b_sel)
  );

  assign dat_o = oe_n ? a_sel  : 1'bz;
  assign flg_o = oe_n ? b_sel  : 1'bz;
  assign clk_o = oe_n ? rclk_i : 1'bz;
endmodule

// File: rtl/rx_line_decoder_chk.sv
`timescale 1ns/1ps
module rx_line_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             srst_n,
  input logic             pos_i,
  input logic             neg_i,
  input logic             bin_mode,
  input logic             cnt_latch,
  input logic             a_sel,
  input logic             b_sel,
  input logic             inc,
  input logic [CNT_W-1:0] viol_cnt,
  input logic [CNT_W-1:0] viol_hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)           cyc <= '0;
    else if (cyc != 3'd7)  cyc <= cyc + 3'd1;
  end

  AST_BIPOLAR_RAILS: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc >= 3'd4 && !bin_mode) |-> (a_sel == $past(pos_i, 4) && b_sel == $past(neg_i, 4))); // R1

  AST_BOTH_RAILS: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc >= 3'd4 && bin_mode && $past(pos_i & neg_i, 4)) |-> (a_sel && b_sel)); // R7

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc >= 3'd1 && $past(viol_cnt) == CNT_MAX && !$past(cnt_latch)) |-> (viol_cnt == CNT_MAX)); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc >= 3'd1 && !$past(cnt_latch) && $past(inc) && $past(viol_cnt) != CNT_MAX)
    |-> (viol_cnt == $past(viol_cnt) + CNT_W'(1))); // R10

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_latch |=> (viol_hold == $past(viol_cnt) && viol_cnt <= CNT_W'(1))); // R11
endmodule

bind rx_line_decoder rx_line_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(rclk_i), .srst_n(srst_n), .pos_i(pos_i), .neg_i(neg_i),
  .bin_mode(bin_mode), .cnt_latch(cnt_latch), .a_sel(a_sel), .b_sel(b_sel),
  .inc(w_viol), .viol_cnt(viol_cnt), .viol_hold(viol_hold)
);

// File: tb/sim_rx_line_decoder.sv
`timescale 1ns/1ps
module sim_rx_line_decoder;
  logic        clk = 1'b0;
  logic        arst_n, pos_i, neg_i, bin_mode, code_hdb3, clk_inv, oe_n, cnt_latch;
  logic        dat_o, flg_o, clk_o;
  logic [15:0] viol_hold;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit          samp_b [64];

  always #2 clk = ~clk;

  rx_line_decoder u0 (
    .rclk_i(clk), .arst_n(arst_n), .pos_i(pos_i), .neg_i(neg_i),
    .bin_mode(bin_mode), .code_hdb3(code_hdb3), .clk_inv(clk_inv), .oe_n(oe_n),
    .cnt_latch(cnt_latch), .dat_o(dat_o), .flg_o(flg_o), .clk_o(clk_o),
    .viol_hold(viol_hold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit inv);
    arst_n = 0; pos_i = 0; neg_i = 0; bin_mode = 0; code_hdb3 = 0;
    clk_inv = inv; oe_n = 1; cnt_latch = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic string rail(input string line, input bit neg);
    string s = line;
    for (int i = 0; i < line.len(); i++) begin
      if (neg) s[i] = (line[i] == "-" || line[i] == "B") ? "1" : "0";
      else     s[i] = (line[i] == "+" || line[i] == "B") ? "1" : "0";
    end
    return s;
  endfunction

  // '+' positive pulse, '-' negative pulse, '0' empty, 'B' both rails
  task automatic play(input string line, input string ed, input string ef,
                      input int nchk, input bit binm, input bit hdb, input string tag);
    code_hdb3 = hdb;
    for (int j = 0; j < line.len(); j++) begin
      @(negedge clk);
      bin_mode = binm;
      pos_i = (line[j] == "+" || line[j] == "B");
      neg_i = (line[j] == "-" || line[j] == "B");
      #1;
      if (j >= 4 && (j - 4) < nchk) begin
        chk(dat_o === (ed[j-4] == "1"), $sformatf("%s data bit %0d", tag, j - 4),
            int'(dat_o), int'(ed[j-4] == "1"));
        chk(flg_o === (ef[j-4] == "1"), $sformatf("%s flag bit %0d", tag, j - 4),
            int'(flg_o), int'(ef[j-4] == "1"));
      end
      @(posedge clk); #1;
      samp_b[j] = dat_o;
    end
    @(negedge clk);
    bin_mode = 0; pos_i = 0; neg_i = 0;
  endtask

  task automatic latch_read(output int val);
    repeat (6) @(negedge clk);
    cnt_latch = 1;
    @(negedge clk);
    cnt_latch = 0;
    #1;
    val = int'(viol_hold);
  endtask

  task automatic t_reset;
    do_reset(0);
    #1;
    chk(dat_o === 1'b0, "R12 reset data", int'(dat_o), 0);
    chk(flg_o === 1'b0, "R12 reset flag", int'(flg_o), 0);
    chk(viol_hold == 16'd0, "R12 reset hold", int'(viol_hold), 0);
  endtask

  task automatic t_bipolar;
    string ln = "+0-B0+-0++0-00B+----";
    do_reset(0);
    play(ln, rail(ln, 0), rail(ln, 1), ln.len() - 4, 0, 0, "R1 bipolar");
  endtask

  task automatic t_zs4;
    int v;
    do_reset(0);
    // R3 000V and B00V, R5 bare V at 17, R6 run of four at 15, R7 both at 18
    play("+-000-+-00-+0000--B+-+-+-+-+", "11000010000100001111",
         "00000000000000010110", 20, 1, 1, "R2 R3 R5 R6 R7 four-zero code");
    latch_read(v);
    chk(v == 3, "R10 R11 four-zero count", v, 3);
  endtask

  task automatic t_zs3;
    int v;
    do_reset(0);
    // R4 00V and B0V, R6 run of three at 12, R5 bare V at 15
    play("+-00-+-0-+000-++-+-+-+-+-", "11000100010001111",
         "00000000000010010", 17, 1, 0, "R2 R4 R5 R6 three-zero code");
    latch_read(v);
    chk(v == 2, "R10 R11 three-zero count", v, 2);
  endtask

  task automatic t_edge;
    string ln = "+0+-0++00+0-++0+0000";
    string ps = rail(ln, 0);
    for (int inv = 1; inv >= 0; inv--) begin
      do_reset(inv[0]);
      play(ln, ps, rail(ln, 1), ln.len() - 4, 0, 0, "R8 edge stream");
      for (int j = 4; j < ln.len(); j++) begin
        int e = (inv == 1) ? int'(ps[j-3] == "1") : int'(ps[j-4] == "1");
        chk(int'(samp_b[j]) == e, $sformatf("R8 edge inv=%0d after rise %0d", inv, j),
            int'(samp_b[j]), e);
      end
    end
  endtask

  task automatic t_tristate;
    int v;
    do_reset(0);
    oe_n = 0;
    @(negedge clk);
    bin_mode = 1; code_hdb3 = 1; pos_i = 1; neg_i = 1;
    repeat (9) @(negedge clk);
    #1;
    chk(dat_o !== 1'b1, "R9 data released", int'(dat_o), 0);
    chk(flg_o !== 1'b1, "R9 flag released", int'(flg_o), 0);
    @(posedge clk); #1;
    chk(clk_o !== 1'b1, "R9 clock released", int'(clk_o), 0);
    @(negedge clk);
    oe_n = 1;
    #1;
    chk(dat_o === 1'b1, "R9 R7 data driven", int'(dat_o), 1);
    chk(flg_o === 1'b1, "R9 R7 flag driven", int'(flg_o), 1);
    @(posedge clk); #1;
    chk(clk_o === 1'b1, "R9 clock driven", int'(clk_o), 1);
    @(negedge clk);
    @(negedge clk);
    bin_mode = 0; pos_i = 0; neg_i = 0;
    latch_read(v);
    chk(v == 12, "R9 R10 count while released", v, 12);
  endtask

  task automatic t_saturate;
    int v;
    do_reset(0);
    @(negedge clk);
    bin_mode = 1; pos_i = 1; neg_i = 1;
    repeat (65545) @(negedge clk);
    bin_mode = 0; pos_i = 0; neg_i = 0;
    latch_read(v);
    chk(v == 65535, "R10 saturation", v, 65535);
    latch_read(v);
    chk(v == 0, "R11 restart after latch", v, 0);
  endtask

  initial begin
    t_reset();
    t_bipolar();
    t_zs4();
    t_zs3();
    t_edge();
    t_tristate();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule